// File: doc/BRIEF.md
# Deferred Line Configuration Shadow

This block keeps the line configuration of an asynchronous serial transmitter: an operating-mode byte, a modem-output byte that carries DTR, a character-format byte that carries the break request, and a 10-bit baud divisor. The host never writes the live registers directly. Each host write lands in a shadow copy and raises one pending flag. A small sequencer copies the shadows into the live registers only while the transmitter reports that it is not busy. Changing the format or divisor in the middle of a character therefore cannot corrupt that character.

The host uses a narrow write port. Addresses 0 to 4 load the mode, modem-output, format, divisor-low and divisor-high shadows as raw values. Address 5 is a modem-control command with RTS in bit 0 and DTR in bit 1. Address 6 sets the break request from bit 0. Address 7 is unused. Any number of updates made before a commit starts are carried by that one commit. An update that arrives while a commit is running raises the pending flag again, and a second commit follows. The live registers can be read back through a read-address port.

Top module: `line_cfg_shadow`

## Requirements
- R1: After reset the live registers hold mode 0x00, modem-output 0x02, format 0x00, divisor-low 0x00 and clock-control 0x15. The pending flag and the sequencer-busy output are low.
- R2: A host write to address 0 to 6 sets the pending flag at the next clock edge. A write to address 7 sets no flag, starts no commit and changes no live register.
- R3: When the pending flag is high, the sequencer is idle and tx_busy is low at a clock edge, a commit starts at that edge and the pending flag clears. On the following edges the live registers are written one per cycle: mode, then modem-output, then format, then divisor-low, then clock-control.
- R4: No live register changes at a clock edge where tx_busy is high. A commit stalls at that edge and resumes at the step where it stopped.
- R5: Divisor bits 7:0 go to the divisor-low register. Divisor bits 9:8 go to clock-control bits 7:6. Clock-control bits 5:0 keep their reset value 0x15.
- R6: A write to address 5 with bit 0 = 1 clears mode bit 3 and sets mode bit 2; with bit 0 = 0 it sets both bits. With bit 1 = 1 it clears modem-output bit 1 (DTR is active-low); with bit 1 = 0 it sets that bit. All other bits are kept.
- R7: A write to address 6 copies its bit 0 into format bit 6. This change is deferred like any other and reaches the line only at a commit.
- R8: Any number of shadow updates made before a commit starts are carried by a single commit.
- R9: A shadow update that arrives while a commit is running sets the pending flag, and a second commit follows once the first has finished.
- R10: A read at rd_addr 0 to 4 returns the live mode, modem-output, format, divisor-low and clock-control registers. A read at rd_addr 5 to 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 3 | Host write address |
| cfg_wdata | input | 8 | Host write data |
| tx_busy | input | 1 | Transmitter busy sending a character |
| rd_addr | input | 3 | Live-register readback address |
| rd_data | output | 8 | Live-register readback data |
| cfg_pending | output | 1 | Shadow update waiting for commit |
| commit_busy | output | 1 | Commit sequencer running |
| line_mode | output | 8 | Live mode register |
| line_pval | output | 8 | Live modem-output register |
| line_fmt | output | 8 | Live character-format register |
| line_brg_lo | output | 8 | Live divisor low byte |
| line_clkctl | output | 8 | Live clock-control register |

## Verification
The assertions assume that tx_busy and the host write strobe are clean synchronous levels. They do not assume that the transmitter stays quiet for the whole of a commit. For that reason the stall property is written per clock edge, not per commit. The bench drives every input on the falling edge. It raises tx_busy both before a commit and in the middle of one, so that both the deferred start and the mid-sequence stall are exercised. No assumption is made about how host writes are spaced: the bench issues back-to-back writes, writes during a commit and writes while the transmitter is busy.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_MODE  = 3'd1,
    SEQ_PVAL  = 3'd2,
    SEQ_FMT   = 3'd3,
    SEQ_BRGLO = 3'd4,
    SEQ_CLK   = 3'd5
  } seq_state_e;

  localparam int NUM_LIVE = 5;

  typedef enum logic [2:0] {
    A_MODE  = 3'd0,
    A_PVAL  = 3'd1,
    A_FMT   = 3'd2,
    A_DIVLO = 3'd3,
    A_DIVHI = 3'd4,
    A_MODEM = 3'd5,
    A_BREAK = 3'd6,
    A_NONE  = 3'd7
  } cfg_addr_e;

  // RTS on: force bit cleared, RTS bit set; RTS off: both set.
  function automatic logic [7:0] mode_with_rts(input logic [7:0] m,
                                               input logic rts_on,
                                               input int rts_bit,
                                               input int frts_bit);
    logic [7:0] r;
    r = m;
    r[rts_bit] = 1'b1;
    r[frts_bit] = !rts_on;
    return r;
  endfunction

  // DTR is active-low in the modem-output byte.
  function automatic logic [7:0] pval_with_dtr(input logic [7:0] p,
                                               input logic dtr_on,
                                               input int dtr_bit);
    logic [7:0] r;
    r = p;
    r[dtr_bit] = !dtr_on;
    return r;
  endfunction

  // Read-modify-write: upper divisor bits into the top of clock control.
  function automatic logic [7:0] clkctl_merge(input logic [7:0] old,
                                              input logic [1:0] div_hi);
    return {div_hi, old[5:0]};
  endfunction

endpackage

// File: rtl/lcs_shadow_bank.sv
module lcs_shadow_bank
  import lcs_pkg::*;
#(
  parameter int         DIV_W     = 10,
  parameter logic [7:0] MODE_RST  = 8'h00,
  parameter logic [7:0] PVAL_RST  = 8'h02,
  parameter logic [7:0] FMT_RST   = 8'h00,
  parameter int         RTS_BIT   = 2,
  parameter int         FRTS_BIT  = 3,
  parameter int         DTR_BIT   = 1,
  parameter int         BRK_BIT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       sh_mode,
  output logic [7:0]       sh_pval,
  output logic [7:0]       sh_fmt,
  output logic [DIV_W-1:0] sh_div,
  output logic             upd
);
  localparam int HI_W = DIV_W - 8;

  cfg_addr_e a;
  assign a   = cfg_addr_e'(addr);
  assign upd = we && (a != A_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode <= MODE_RST;
      sh_pval <= PVAL_RST;
      sh_fmt  <= FMT_RST;
      sh_div  <= '0;
    end else if (we) begin
      case (a)
        A_MODE:  sh_mode <= wdata;
        A_PVAL:  sh_pval <= wdata;
        A_FMT:   sh_fmt  <= wdata;
        A_DIVLO: sh_div[7:0] <= wdata;
        A_DIVHI: sh_div[DIV_W-1:8] <= wdata[HI_W-1:0];
        A_MODEM: begin
          sh_mode <= mode_with_rts(sh_mode, wdata[0], RTS_BIT, FRTS_BIT);
          sh_pval <= pval_with_dtr(sh_pval, wdata[1], DTR_BIT);
        end
        A_BREAK: sh_fmt[BRK_BIT] <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcs_commit_seq.sv
module lcs_commit_seq
  import lcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic                tx_busy,
  output logic                pending,
  output logic                start,
  output logic                running,
  output logic [NUM_LIVE-1:0] wr_vec
);
  seq_state_e state, state_nx;

  assign start   = (state == SEQ_IDLE) && pending && !tx_busy;
  assign running = (state != SEQ_IDLE);

  always_comb begin
    state_nx = state;
    case (state)
      SEQ_IDLE:  if (start)    state_nx = SEQ_MODE;
      SEQ_MODE:  if (!tx_busy) state_nx = SEQ_PVAL;
      SEQ_PVAL:  if (!tx_busy) state_nx = SEQ_FMT;
      SEQ_FMT:   if (!tx_busy) state_nx = SEQ_BRGLO;
      SEQ_BRGLO: if (!tx_busy) state_nx = SEQ_CLK;
      SEQ_CLK:   if (!tx_busy) state_nx = SEQ_IDLE;
      default:   state_nx = SEQ_IDLE;
    endcase
  end

  for (genvar i = 0; i < NUM_LIVE; i++) begin : g_wr
    assign wr_vec[i] = !tx_busy && (state == seq_state_e'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      pending <= 1'b0;
    end else begin
      state <= state_nx;
      if (upd)        pending <= 1'b1;
      else if (start) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/lcs_live_regs.sv
module lcs_live_regs
  import lcs_pkg::*;
#(
  parameter int         DIV_W      = 10,
  parameter logic [7:0] MODE_RST   = 8'h00,
  parameter logic [7:0] PVAL_RST   = 8'h02,
  parameter logic [7:0] FMT_RST    = 8'h00,
  parameter logic [5:0] CLKLO_RST  = 6'h15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LIVE-1:0] wr_vec,
  input  logic [7:0]          sh_mode,
  input  logic [7:0]          sh_pval,
  input  logic [7:0]          sh_fmt,
  input  logic [DIV_W-1:0]    sh_div,
  output logic [7:0]          lv_mode,
  output logic [7:0]          lv_pval,
  output logic [7:0]          lv_fmt,
  output logic [7:0]          lv_brg_lo,
  output logic [7:0]          lv_clkctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_mode   <= MODE_RST;
      lv_pval   <= PVAL_RST;
      lv_fmt    <= FMT_RST;
      lv_brg_lo <= 8'h00;
      lv_clkctl <= {2'b00, CLKLO_RST};
    end else begin
      if (wr_vec[0]) lv_mode   <= sh_mode;
      if (wr_vec[1]) lv_pval   <= sh_pval;
      if (wr_vec[2]) lv_fmt    <= sh_fmt;
      if (wr_vec[3]) lv_brg_lo <= sh_div[7:0];
      if (wr_vec[4]) lv_clkctl <= clkctl_merge(lv_clkctl, sh_div[DIV_W-1:8]);
    end
  end
endmodule

// File: rtl/line_cfg_shadow.sv
module line_cfg_shadow
  import lcs_pkg::*;
#(
  parameter int         DIV_W     = 10,
  parameter logic [7:0] MODE_RST  = 8'h00,
  parameter logic [7:0] PVAL_RST  = 8'h02,
  parameter logic [7:0] FMT_RST   = 8'h00,
  parameter logic [5:0] CLKLO_RST = 6'h15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       tx_busy,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       cfg_pending,
  output logic       commit_busy,
  output logic [7:0] line_mode,
  output logic [7:0] line_pval,
  output logic [7:0] line_fmt,
  output logic [7:0] line_brg_lo,
  output logic [7:0] line_clkctl
);
  logic [7:0]          sh_mode, sh_pval, sh_fmt;
  logic [DIV_W-1:0]    sh_div;
  logic                shadow_upd;
  logic                commit_start;
  logic [NUM_LIVE-1:0] commit_wr;

  lcs_shadow_bank #(
    .DIV_W(DIV_W), .MODE_RST(MODE_RST), .PVAL_RST(PVAL_RST), .FMT_RST(FMT_RST)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sh_mode(sh_mode), .sh_pval(sh_pval), .sh_fmt(sh_fmt), .sh_div(sh_div),
    .upd(shadow_upd)
  );

  lcs_commit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .upd(shadow_upd), .tx_busy(tx_busy),
    .pending(cfg_pending), .start(commit_start), .running(commit_busy),
    .wr_vec(commit_wr)
  );

  lcs_live_regs #(
    .DIV_W(DIV_W), .MODE_RST(MODE_RST), .PVAL_RST(PVAL_RST), .FMT_RST(FMT_RST),
    .CLKLO_RST(CLKLO_RST)
  ) u_live (
    .clk(clk), .rst_n(rst_n), .wr_vec(commit_wr),
    .sh_mode(sh_mode), .sh_pval(sh_pval), .sh_fmt(sh_fmt), .sh_div(sh_div),
    .lv_mode(line_mode), .lv_pval(line_pval), .lv_fmt(line_fmt),
    .lv_brg_lo(line_brg_lo), .lv_clkctl(line_clkctl)
  );

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = line_mode;
      3'd1:    rd_data = line_pval;
      3'd2:    rd_data = line_fmt;
      3'd3:    rd_data = line_brg_lo;
      3'd4:    rd_data = line_clkctl;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic       tx_busy,
  input logic       cfg_pending,
  input logic       commit_busy,
  input logic [4:0] commit_wr,
  input logic [7:0] line_mode,
  input logic [7:0] line_pval,
  input logic [7:0] line_fmt,
  input logic [7:0] line_brg_lo,
  input logic [7:0] line_clkctl
);
  // R4
  live_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> ($stable(line_mode) && $stable(line_pval) && $stable(line_fmt)
                 && $stable(line_brg_lo) && $stable(line_clkctl)));

  // R2
  upd_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != 3'd7) |=> cfg_pending);

  // R2
  unused_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd7 && !cfg_pending && !commit_busy) |=> !cfg_pending);

  // R3
  commit_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && !commit_busy && !tx_busy && !cfg_we) |=> (commit_busy && !cfg_pending));

  // R3
  one_write_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_wr));

  // R3
  mode_then_pval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr[0] |=> (commit_wr[1] || tx_busy));

  // R3
  fmt_then_brg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr[2] |=> (commit_wr[3] || tx_busy));

  // R5
  clk_low_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(line_clkctl[5:0]));
endmodule

bind line_cfg_shadow lcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .tx_busy(tx_busy), .cfg_pending(cfg_pending), .commit_busy(commit_busy),
  .commit_wr(commit_wr), .line_mode(line_mode), .line_pval(line_pval),
  .line_fmt(line_fmt), .line_brg_lo(line_brg_lo), .line_clkctl(line_clkctl)
);

// File: tb/line_cfg_shadow_tb.sv
module line_cfg_shadow_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       tx_busy = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       cfg_pending, commit_busy;
  logic [7:0] line_mode, line_pval, line_fmt, line_brg_lo, line_clkctl;

  int checks = 0;
  int fails = 0;
  int commits = 0;
  logic prev_busy = 1'b0;

  line_cfg_shadow u_dut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (commit_busy && !prev_busy) commits++;
    prev_busy <= commit_busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 40; i++) begin
      if (!cfg_pending && !commit_busy) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [39:0] snap();
    return {line_clkctl, line_brg_lo, line_fmt, line_pval, line_mode};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [39:0] s0, s1;
    logic [7:0]  mode_exp, pval_exp, fmt_exp;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(line_mode == 8'h00, "R1 mode", line_mode, 8'h00);
    check(line_pval == 8'h02, "R1 pval", line_pval, 8'h02);
    check(line_fmt == 8'h00, "R1 fmt", line_fmt, 8'h00);
    check(line_brg_lo == 8'h00, "R1 brg", line_brg_lo, 8'h00);
    check(line_clkctl == 8'h15, "R1 clkctl", line_clkctl, 8'h15);
    check(!cfg_pending && !commit_busy, "R1 idle", {cfg_pending, commit_busy}, 0);

    // R10 readback of every address
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      case (a)
        0: check(rd_data == line_mode, "R10 rd0", rd_data, line_mode);
        1: check(rd_data == line_pval, "R10 rd1", rd_data, line_pval);
        2: check(rd_data == line_fmt, "R10 rd2", rd_data, line_fmt);
        3: check(rd_data == line_brg_lo, "R10 rd3", rd_data, line_brg_lo);
        4: check(rd_data == line_clkctl, "R10 rd4", rd_data, line_clkctl);
        default: check(rd_data == 8'h00, "R10 rd_unused", rd_data, 0);
      endcase
    end

    // R2 unused address: nothing happens
    s0 = snap();
    wr(3'd7, 8'hFF);
    check(!cfg_pending, "R2 addr7 pending", cfg_pending, 0);
    repeat (8) @(negedge clk);
    check(!commit_busy && snap() == s0, "R2 addr7 live", int'(snap() != s0), 0);

    // R2/R4/R8/R3: updates while busy are held, then one ordered commit
    tx_busy = 1'b1;
    c0 = commits;
    s0 = snap();
    wr(3'd0, 8'hA1);
    check(cfg_pending, "R2 pending", cfg_pending, 1);
    wr(3'd1, 8'h5C);
    wr(3'd2, 8'h33);
    wr(3'd3, 8'h9E);
    wr(3'd4, 8'h03);
    repeat (30) @(negedge clk);
    check(snap() == s0 && !commit_busy, "R4 held while busy", int'(snap() != s0), 0);
    tx_busy = 1'b0;
    @(negedge clk);
    s1 = snap();
    check(s1 == s0 && commit_busy && !cfg_pending, "R3 start cycle", int'(s1 != s0), 0);
    for (int k = 0; k < NUM_STEPS; k++) begin
      @(negedge clk);
      s0 = s1; s1 = snap();
      check(((s0 ^ s1) != 0) && ((s0 ^ s1) & ~(40'hFF << (8 * k))) == 0,
            "R3 order", int'(k), k);
    end
    check(line_mode == 8'hA1 && line_pval == 8'h5C && line_fmt == 8'h33,
          "R3 values", line_fmt, 8'h33);
    check(line_brg_lo == 8'h9E && line_clkctl == 8'hD5, "R5 divisor", line_clkctl, 8'hD5);
    @(negedge clk);
    check(commits - c0 == 1, "R8 single commit", commits - c0, 1);

    // R4 stall mid-commit
    wr(3'd2, 8'h44);
    @(negedge clk);
    @(negedge clk); // mode written
    tx_busy = 1'b1;
    s0 = snap();
    repeat (6) @(negedge clk);
    check(snap() == s0 && commit_busy, "R4 stall", int'(snap() != s0), 0);
    tx_busy = 1'b0;
    settle();
    check(line_fmt == 8'h44, "R4 resume", line_fmt, 8'h44);

    // R9 update during a commit causes a second commit
    c0 = commits;
    wr(3'd0, 8'h11);
    @(negedge clk);
    @(negedge clk);
    wr(3'd2, 8'h77);
    settle();
    check(commits - c0 == 2, "R9 second commit", commits - c0, 2);
    check(line_fmt == 8'h77 && line_mode == 8'h11, "R9 values", line_fmt, 8'h77);

    // R6 modem control sweep
    mode_exp = line_mode; pval_exp = line_pval;
    for (int m = 0; m < 4; m++) begin
      wr(3'd5, 8'(m));
      settle();
      mode_exp[2] = 1'b1; mode_exp[3] = (m & 1) == 0;
      pval_exp[1] = (m & 2) == 0;
      check(line_mode == mode_exp, "R6 mode", line_mode, mode_exp);
      check(line_pval == pval_exp, "R6 pval", line_pval, pval_exp);
    end

    // R7 break deferred
    fmt_exp = line_fmt;
    tx_busy = 1'b1;
    wr(3'd6, 8'h01);
    repeat (5) @(negedge clk);
    check(line_fmt == fmt_exp, "R7 break deferred", line_fmt, fmt_exp);
    tx_busy = 1'b0;
    settle();
    fmt_exp[6] = 1'b1;
    check(line_fmt == fmt_exp, "R7 break on", line_fmt, fmt_exp);
    wr(3'd6, 8'h00);
    settle();
    fmt_exp[6] = 1'b0;
    check(line_fmt == fmt_exp, "R7 break off", line_fmt, fmt_exp);

    // R5 full divisor sweep
    for (int d = 0; d < 1024; d++) begin
      wr(3'd3, 8'(d % 256));
      wr(3'd4, 8'(d / 256));
      settle();
      check(line_brg_lo == 8'(d % 256), "R5 low", line_brg_lo, d % 256);
      check(line_clkctl == 8'(((d / 256) * 64) + 8'h15), "R5 clkctl",
            line_clkctl, ((d / 256) * 64) + 8'h15);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam int NUM_STEPS = 5;
endmodule